// File: doc/BRIEF.md
# Equality-Branch Counter Machine Core

This block runs small programs over a bank of unsigned counters. It has only three data operations: clear a counter, add one to a counter, and branch to an absolute program location when two counters hold the same value. A fourth opcode stops the machine. A decrement or a zero test is not native to the machine. Programs build them from these operations. A zero test compares a counter against slot 0, which always reads zero. A decrement is a loop that counts two scratch counters up until one of them matches the operand.

The host writes instruction words into the program store and presets counters while the core is idle. It pulses `start`, waits for `halted`, and then reads any counter back through a combinational read port. The core executes one instruction per clock. It stops on the halt opcode. It also stops, with an error flag, when the next location would fall past the end of the program store. Counter count, counter width and program depth are parameters.

Top module: `succ_cm_core`

## Requirements
- R1: After reset `busy`, `halted`, `err` and `ovf` are 0 and every counter reads 0.
- R2: While idle, a host counter write is visible on `rd_data` in the next cycle. Slot 0 always reads 0, and host writes to slot 0 are dropped.
- R3: Opcode 00 (clear) sets the named counter to 0 and continues with the next location.
- R4: Opcode 01 (increment) adds one to the named counter and continues with the next location. At all-ones the counter wraps to 0 and `ovf` is set. `ovf` stays set until the next accepted start.
- R5: Opcode 10 (equal-branch) loads the target field into the program counter when the two named counters are equal, and otherwise continues with the next location. Naming the same counter twice gives an unconditional branch. At default parameters the word is 13 bits: opcode in [12:11], first counter in [10:8], second counter in [7:5], target in [4:0].
- R6: An equal-branch against slot 0 acts as a branch-if-zero on the other counter.
- R7: An accepted start begins at location 0 with one instruction per clock. Opcode 11 ends the run, so a run of N executed instructions keeps `busy` high for exactly N cycles, after which `halted` is 1 and `err` is 0.
- R8: If the instruction in the last location does not branch, it still takes effect, and the core then halts with `err` set. The next start clears `err`.
- R9: While busy, program writes, counter writes and further start pulses are ignored.
- R10: Clear and increment aimed at slot 0 change nothing and never set `ovf`.
- R11: The 14-instruction decrement program built from these operations lowers a nonzero counter by one and leaves a zero counter at zero. Its scratch counters end at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Program store write enable (idle only) |
| prog_addr | input | PAW | Program store write location |
| prog_wdata | input | IW | Instruction word to store |
| reg_we | input | 1 | Counter preset enable (idle only) |
| reg_addr | input | RAW | Counter preset index |
| reg_wdata | input | DW | Counter preset value |
| rd_addr | input | RAW | Counter readout index |
| rd_data | output | DW | Counter readout value (combinational) |
| start | input | 1 | Start pulse, accepted when idle |
| busy | output | 1 | Program running |
| halted | output | 1 | Last run has ended |
| err | output | 1 | Last run ran past the program store |
| ovf | output | 1 | Sticky counter wrap flag |

## Verification
A host write made at one edge shows on `rd_data` at the next falling edge. A start taken at an edge raises `busy` by the following falling edge. Each executed instruction then takes exactly one further edge, and `halted` and `err` are set by the edge that executes the last instruction. The bench drives its inputs and samples at falling edges. It counts the falling edges during which `busy` is high and compares that count with the number of instructions along the path the program must take. It reads counters only after `busy` has dropped. The checks made while a run is in progress hold that run's result up against the value expected from an undisturbed run.

// File: rtl/scm_pkg.sv
package scm_pkg;
   typedef enum logic [1:0] {
      OP_CLR  = 2'b00,
      OP_INC  = 2'b01,
      OP_JEQ  = 2'b10,
      OP_STOP = 2'b11
   } scm_op_e;
endpackage

// File: rtl/scm_regs.sv
module scm_regs #(
   parameter int NREG = 8,
   parameter int DW   = 8,
   parameter int RAW  = $clog2(NREG)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [RAW-1:0] widx,
   input  logic [DW-1:0]  wval,
   input  logic [RAW-1:0] a_idx,
   output logic [DW-1:0]  a_val,
   input  logic [RAW-1:0] b_idx,
   output logic [DW-1:0]  b_val,
   input  logic [RAW-1:0] c_idx,
   output logic [DW-1:0]  c_val
);
   // slot 0 has no storage: it is the constant zero
   logic [DW-1:0] cnt [1:NREG-1];

   function automatic logic [DW-1:0] peek(input logic [RAW-1:0] i);
      if (i == '0 || int'(i) >= NREG) return '0;
      return cnt[i];
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 1; i < NREG; i++) cnt[i] <= '0;
      end else if (we) begin
         for (int i = 1; i < NREG; i++)
            if (widx == RAW'(i)) cnt[i] <= wval;
      end
   end

   assign a_val = peek(a_idx);
   assign b_val = peek(b_idx);
   assign c_val = peek(c_idx);
endmodule

// File: rtl/scm_store.sv
module scm_store #(
   parameter int PDEPTH = 32,
   parameter int IW     = 13,
   parameter int PAW    = $clog2(PDEPTH)
) (
   input  logic           clk,
   input  logic           we,
   input  logic [PAW-1:0] waddr,
   input  logic [IW-1:0]  wdata,
   input  logic [PAW-1:0] raddr,
   output logic [IW-1:0]  rdata
);
   logic [IW-1:0] mem [PDEPTH];

   always_ff @(posedge clk) begin
      if (we && int'(waddr) < PDEPTH) mem[waddr] <= wdata;
   end

   assign rdata = (int'(raddr) < PDEPTH) ? mem[raddr] : '0;
endmodule

// File: rtl/scm_seq.sv
module scm_seq
   import scm_pkg::*;
#(
   parameter int NREG   = 8,
   parameter int DW     = 8,
   parameter int PDEPTH = 32,
   parameter int RAW    = $clog2(NREG),
   parameter int PAW    = $clog2(PDEPTH),
   parameter int IW     = 2 + 2*RAW + PAW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [IW-1:0]  instr,
   input  logic [DW-1:0]  va,
   input  logic [DW-1:0]  vb,
   output logic [PAW-1:0] pc,
   output logic [RAW-1:0] ra,
   output logic [RAW-1:0] rb,
   output logic           ex_we,
   output logic [DW-1:0]  ex_val,
   output logic           busy,
   output logic           halted,
   output logic           err,
   output logic           ovf
);
   scm_op_e        op;
   logic [PAW-1:0] tgt;
   logic [PAW:0]   nxt;
   logic           beyond;
   logic           wraps;

   always_comb begin
      op     = scm_op_e'(instr[IW-1 -: 2]);
      ra     = instr[IW-3 -: RAW];
      rb     = instr[PAW+RAW-1 -: RAW];
      tgt    = instr[PAW-1:0];
      nxt    = {1'b0, pc} + 1'b1;
      ex_we  = 1'b0;
      ex_val = '0;
      wraps  = 1'b0;
      unique case (op)
         OP_CLR: ex_we = busy && (ra != '0);
         OP_INC: begin
            ex_we  = busy && (ra != '0);
            ex_val = va + 1'b1;
            wraps  = (ra != '0) && (va == '1);
         end
         OP_JEQ:  if (va == vb) nxt = {1'b0, tgt};
         OP_STOP: ;
         default: ;
      endcase
   end

   // with a power-of-two depth only the carry can leave the store
   generate
      if (PDEPTH == (1 << PAW)) begin : g_pow2
         assign beyond = nxt[PAW];
      end else begin : g_odd
         assign beyond = (nxt >= (PAW+1)'(PDEPTH));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc     <= '0;
         busy   <= 1'b0;
         halted <= 1'b0;
         err    <= 1'b0;
         ovf    <= 1'b0;
      end else if (!busy) begin
         if (start) begin
            pc     <= '0;
            busy   <= 1'b1;
            halted <= 1'b0;
            err    <= 1'b0;
            ovf    <= 1'b0;
         end
      end else begin
         if (wraps) ovf <= 1'b1;
         if (op == OP_STOP) begin
            busy   <= 1'b0;
            halted <= 1'b1;
         end else if (beyond) begin
            busy   <= 1'b0;
            halted <= 1'b1;
            err    <= 1'b1;
         end else begin
            pc <= nxt[PAW-1:0];
         end
      end
   end
endmodule

// File: rtl/succ_cm_core.sv
module succ_cm_core #(
   parameter int NREG   = 8,
   parameter int DW     = 8,
   parameter int PDEPTH = 32,
   parameter int RAW    = $clog2(NREG),
   parameter int PAW    = $clog2(PDEPTH),
   parameter int IW     = 2 + 2*RAW + PAW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           prog_we,
   input  logic [PAW-1:0] prog_addr,
   input  logic [IW-1:0]  prog_wdata,
   input  logic           reg_we,
   input  logic [RAW-1:0] reg_addr,
   input  logic [DW-1:0]  reg_wdata,
   input  logic [RAW-1:0] rd_addr,
   output logic [DW-1:0]  rd_data,
   input  logic           start,
   output logic           busy,
   output logic           halted,
   output logic           err,
   output logic           ovf
);
   generate
      if (NREG < 2 || DW < 1 || PDEPTH < 2 || IW != 2 + 2*RAW + PAW) begin : g_bad_cfg
         $error("succ_cm_core: unsupported parameter set");
      end
   endgenerate

   logic [PAW-1:0] pc;
   logic [IW-1:0]  instr;
   logic [RAW-1:0] ra, rb;
   logic [DW-1:0]  va, vb;
   logic           ex_we;
   logic [DW-1:0]  ex_val;
   logic           f_we;
   logic [RAW-1:0] f_idx;
   logic [DW-1:0]  f_val;

   // host owns the write port only while idle
   assign f_we  = busy ? ex_we  : reg_we;
   assign f_idx = busy ? ra     : reg_addr;
   assign f_val = busy ? ex_val : reg_wdata;

   scm_store #(.PDEPTH(PDEPTH), .IW(IW), .PAW(PAW)) store_i (
      .clk   (clk),
      .we    (prog_we && !busy),
      .waddr (prog_addr),
      .wdata (prog_wdata),
      .raddr (pc),
      .rdata (instr)
   );

   scm_regs #(.NREG(NREG), .DW(DW), .RAW(RAW)) regs_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (f_we),
      .widx  (f_idx),
      .wval  (f_val),
      .a_idx (ra),
      .a_val (va),
      .b_idx (rb),
      .b_val (vb),
      .c_idx (rd_addr),
      .c_val (rd_data)
   );

   scm_seq #(.NREG(NREG), .DW(DW), .PDEPTH(PDEPTH), .RAW(RAW), .PAW(PAW), .IW(IW)) seq_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .instr  (instr),
      .va     (va),
      .vb     (vb),
      .pc     (pc),
      .ra     (ra),
      .rb     (rb),
      .ex_we  (ex_we),
      .ex_val (ex_val),
      .busy   (busy),
      .halted (halted),
      .err    (err),
      .ovf    (ovf)
   );
endmodule

// File: rtl/succ_cm_core_chk.sv
module succ_cm_core_chk #(
   parameter int DW  = 8,
   parameter int RAW = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic           busy,
   input logic           halted,
   input logic           err,
   input logic           ovf,
   input logic [RAW-1:0] rd_addr,
   input logic [DW-1:0]  rd_data
);
   p_run_or_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && halted));

   p_err_means_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> halted);

   p_slot0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == '0) |-> (rd_data == '0));

   p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !halted && !err && !ovf));

   p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !start) |=> ovf);

   p_idle_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> (!busy && $stable(halted) && $stable(err)));
endmodule

bind succ_cm_core succ_cm_core_chk #(.DW(DW), .RAW(RAW)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .halted  (halted),
   .err     (err),
   .ovf     (ovf),
   .rd_addr (rd_addr),
   .rd_data (rd_data)
);

// File: tb/succ_cm_core_tb_top.sv
module succ_cm_core_tb_top;
   localparam int NREG   = 8;
   localparam int DW     = 8;
   localparam int PDEPTH = 32;
   localparam int RAW    = 3;
   localparam int PAW    = 5;
   localparam int IW     = 13;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           prog_we = 1'b0;
   logic [PAW-1:0] prog_addr = '0;
   logic [IW-1:0]  prog_wdata = '0;
   logic           reg_we = 1'b0;
   logic [RAW-1:0] reg_addr = '0;
   logic [DW-1:0]  reg_wdata = '0;
   logic [RAW-1:0] rd_addr = '0;
   logic [DW-1:0]  rd_data;
   logic           start = 1'b0;
   logic           busy, halted, err, ovf;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   succ_cm_core #(.NREG(NREG), .DW(DW), .PDEPTH(PDEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .prog_we(prog_we), .prog_addr(prog_addr), .prog_wdata(prog_wdata),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .start(start), .busy(busy), .halted(halted), .err(err), .ovf(ovf)
   );

   function automatic logic [IW-1:0] w(input int op, input int a, input int b, input int t);
      return {op[1:0], a[RAW-1:0], b[RAW-1:0], t[PAW-1:0]};
   endfunction
   function automatic logic [IW-1:0] w_clr(input int a); return w(0, a, 0, 0); endfunction
   function automatic logic [IW-1:0] w_inc(input int a); return w(1, a, 0, 0); endfunction
   function automatic logic [IW-1:0] w_jeq(input int a, input int b, input int t); return w(2, a, b, t); endfunction
   function automatic logic [IW-1:0] w_stop(); return w(3, 0, 0, 0); endfunction

   task automatic chk(input string tag, input int got, input int exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic load(input int a, input logic [IW-1:0] d);
      @(negedge clk);
      prog_we = 1'b1; prog_addr = a[PAW-1:0]; prog_wdata = d;
      @(negedge clk);
      prog_we = 1'b0;
   endtask

   task automatic preset(input int a, input int v);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a[RAW-1:0]; reg_wdata = v[DW-1:0];
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic peek(input int a, output int v);
      rd_addr = a[RAW-1:0];
      #1;
      v = int'(rd_data);
   endtask

   task automatic run(output int cyc);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (busy && cyc < 5000) begin
         cyc++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      int v;
      chk("R1 busy", int'(busy), 0);
      chk("R1 halted", int'(halted), 0);
      chk("R1 err", int'(err), 0);
      chk("R1 ovf", int'(ovf), 0);
      for (int i = 0; i < NREG; i++) begin
         peek(i, v);
         chk($sformatf("R1 counter %0d", i), v, 0);
      end
   endtask

   task automatic t_preset();
      int v;
      preset(3, 8'h5A);
      peek(3, v); chk("R2 preset r3", v, 8'h5A);
      preset(0, 7);
      peek(0, v); chk("R2 slot0 write dropped", v, 0);
   endtask

   task automatic t_clr_inc();
      int v, c;
      preset(1, 9); preset(2, 4);
      load(0, w_clr(1)); load(1, w_inc(2)); load(2, w_inc(2)); load(3, w_stop());
      run(c);
      chk("R7 cycles clr/inc", c, 4);
      peek(1, v); chk("R3 clear r1", v, 0);
      peek(2, v); chk("R4 inc r2 twice", v, 6);
      chk("R7 halted", int'(halted), 1);
      chk("R7 no err", int'(err), 0);
      chk("R4 no ovf", int'(ovf), 0);
   endtask

   task automatic t_jeq();
      int v, c;
      load(0, w_jeq(1, 2, 3)); load(1, w_inc(3)); load(2, w_stop());
      load(3, w_inc(3)); load(4, w_inc(3)); load(5, w_stop());
      preset(1, 3); preset(2, 3); preset(3, 0);
      run(c);
      chk("R5 taken cycles", c, 4);
      peek(3, v); chk("R5 taken path", v, 2);
      preset(2, 4); preset(3, 0);
      run(c);
      chk("R5 not-taken cycles", c, 3);
      peek(3, v); chk("R5 not-taken path", v, 1);
   endtask

   task automatic t_jz();
      int v, c;
      load(0, w_jeq(1, 0, 3)); load(1, w_inc(4)); load(2, w_jeq(6, 6, 4));
      load(3, w_inc(5)); load(4, w_stop());
      preset(1, 0); preset(4, 0); preset(5, 0); preset(6, 77);
      run(c);
      chk("R6 zero branch cycles", c, 3);
      peek(5, v); chk("R6 zero path r5", v, 1);
      peek(4, v); chk("R6 zero path r4", v, 0);
      preset(1, 2); preset(5, 0);
      run(c);
      chk("R5 unconditional cycles", c, 4);
      peek(4, v); chk("R6 nonzero path r4", v, 1);
      peek(5, v); chk("R5 unconditional skipped r5", v, 0);
   endtask

   task automatic t_ovf();
      int v, c;
      load(0, w_inc(1)); load(1, w_inc(1)); load(2, w_stop());
      preset(1, 8'hFF);
      run(c);
      peek(1, v); chk("R4 wrap then inc", v, 1);
      chk("R4 ovf sticky", int'(ovf), 1);
      preset(1, 5);
      run(c);
      peek(1, v); chk("R4 plain inc", v, 7);
      chk("R4 ovf cleared by start", int'(ovf), 0);
   endtask

   task automatic t_slot0();
      int v, c;
      load(0, w_inc(0)); load(1, w_clr(0)); load(2, w_jeq(0, 7, 4));
      load(3, w_stop()); load(4, w_inc(6)); load(5, w_stop());
      preset(7, 0); preset(6, 0);
      run(c);
      peek(6, v); chk("R10 slot0 still zero", v, 1);
      peek(0, v); chk("R10 slot0 reads zero", v, 0);
      chk("R10 no ovf", int'(ovf), 0);
   endtask

   task automatic t_end();
      int v, c;
      load(0, w_jeq(0, 0, PDEPTH-2)); load(PDEPTH-2, w_inc(1)); load(PDEPTH-1, w_inc(1));
      preset(1, 10);
      run(c);
      chk("R8 cycles", c, 3);
      peek(1, v); chk("R8 last location executed", v, 12);
      chk("R8 err", int'(err), 1);
      chk("R8 halted", int'(halted), 1);
      load(0, w_stop());
      run(c);
      chk("R8 err cleared", int'(err), 0);
   endtask

   task automatic t_busy_ignore();
      int v, c;
      load(0, w_inc(1)); load(1, w_jeq(1, 2, 3)); load(2, w_jeq(0, 0, 0));
      load(3, w_stop());
      preset(1, 0); preset(2, 20); preset(3, 8'h11); preset(4, 0);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      c = 0;
      while (busy && c < 5000) begin
         c++;
         if (c == 5) begin
            reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h33;
            prog_we = 1'b1; prog_addr = 5'd3; prog_wdata = w_inc(4);
            start = 1'b1;
         end else begin
            reg_we = 1'b0; prog_we = 1'b0; start = 1'b0;
         end
         @(negedge clk);
      end
      reg_we = 1'b0; prog_we = 1'b0; start = 1'b0;
      chk("R9 cycles unchanged", c, 60);
      peek(1, v); chk("R9 loop result", v, 20);
      peek(3, v); chk("R9 counter write ignored", v, 8'h11);
      peek(4, v); chk("R9 program write ignored r4", v, 0);
      chk("R9 program write ignored err", int'(err), 0);
   endtask

   task automatic dec_case(input int x);
      int v, c;
      preset(5, x); preset(2, 9); preset(3, 9);
      run(c);
      peek(5, v); chk($sformatf("R11 dec of %0d", x), v, (x > 0) ? x - 1 : 0);
      peek(2, v); chk("R11 scratch r2", v, 0);
      peek(3, v); chk("R11 scratch r3", v, 0);
      chk("R11 no err", int'(err), 0);
   endtask

   task automatic t_dec();
      load(0, w_clr(2));       load(1, w_clr(3));
      load(2, w_jeq(5, 2, 11)); load(3, w_inc(2));
      load(4, w_jeq(5, 2, 7));  load(5, w_inc(3));
      load(6, w_jeq(0, 0, 3));  load(7, w_clr(5));
      load(8, w_jeq(5, 3, 11)); load(9, w_inc(5));
      load(10, w_jeq(0, 0, 8)); load(11, w_clr(2));
      load(12, w_clr(3));       load(13, w_stop());
      dec_case(3);
      dec_case(1);
      dec_case(0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_preset();
      t_clr_inc();
      t_jeq();
      t_jz();
      t_ovf();
      t_slot0();
      t_end();
      t_busy_ignore();
      t_dec();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule